// File: doc/BRIEF.md
# Transition-Minimising Bus Inverter

This block sits in front of two wide pixel output buses (an odd bus and an even bus) and cuts the number of wires that switch from one pixel word to the next. For every valid word on a bus it counts how many bits differ from the word that bus drove last. When more than half of the bits would change, it drives the bitwise complement instead and raises that bus's polarity line. The receiving column driver uses the polarity line to undo the inversion.

Each bus has its own encoder lane with its own stored word and polarity line. When the two buses are skewed against each other, the two lanes therefore stay correct. Encoding runs only while the enable input is high and single-bus mode is off. Otherwise every word passes through unchanged and both polarity lines stay low. The encoded word and its polarity flag are registered and appear one clock after the valid cycle that carried the word.

Top module: `tmin_bus_inverter`

## Requirements
- R1: After a synchronous active-low reset, both data outputs and both polarity outputs are 0, and each lane's stored last-driven word is 0.
- R2: On a valid cycle while encoding is active (enable high, single-bus mode low), if more than 18 of the 36 bits of the input differ from the lane's last-driven word, then from the next clock the lane drives the bitwise inverse of the input and its polarity output is 1.
- R3: On a valid cycle while encoding is active, if 18 or fewer bits differ (exactly 18 included), the lane drives the input unchanged from the next clock with polarity 0.
- R4: The toggle count is taken against the word the lane actually drove last, after any inversion, and not against the previous raw input.
- R5: While the enable input is low, a valid word is driven unchanged with polarity 0, and a polarity output still at 1 falls to 0 on the next clock even with no valid word.
- R6: While the single-bus mode input is high, both lanes behave as in R5 whatever the enable input is.
- R7: On a cycle without valid, a lane's data output and stored word keep their value, and while encoding is active its polarity output keeps its value too.
- R8: The odd and even lanes are independent: each lane uses only its own valid, data, stored word and polarity, so different streams on the two buses are encoded separately in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Enables transition-minimising encoding |
| single_bus_i | input | 1 | Single-bus configuration; forces encoding off |
| odd_data_i | input | 36 | Odd-bus pixel word |
| odd_valid_i | input | 1 | Odd-bus word valid |
| even_data_i | input | 36 | Even-bus pixel word |
| even_valid_i | input | 1 | Even-bus word valid |
| odd_data_o | output | 36 | Encoded odd-bus word (registered) |
| odd_pol_o | output | 1 | Odd-bus polarity, 1 = word is inverted |
| even_data_o | output | 36 | Encoded even-bus word (registered) |
| even_pol_o | output | 1 | Even-bus polarity, 1 = word is inverted |

## Verification
The main stimulus walks every toggle count from 0 to 36 on the odd bus. At the same time the even bus is driven with the mirrored count and a different bit placement. This sweep separates the inverting side of the threshold from the passing side, pins down the exact boundary at 18 against 19, and shows that the two lanes do not interfere. A pair of all-ones words after an all-zeros start tells a comparison against the driven word apart from one against the raw previous input. Idle cycles with changing data, disabled and single-bus phases, and a long pseudo-random stream with mixed valid and enable settings test hold behaviour, pass-through, polarity clearing and general agreement with an arithmetic model.

// File: rtl/tmin_bi_pkg.sv
// Package: shared constants and types for the transition-minimising bus inverter.
// Assumes: exactly two output buses (odd and even), indexed by bus_sel_e.
package tmin_bi_pkg;

    localparam int NUM_BUS = 2;

    typedef enum logic [0:0] {
        BUS_ODD  = 1'b0,
        BUS_EVEN = 1'b1
    } bus_sel_e;

endpackage

// File: rtl/tmin_bi_popcount.sv
// Module: tmin_bi_popcount
// Counts how many bits are set in a word. It is used to count the bits that would
// toggle between two words.
// Assumes: W >= 1; the result is purely combinational.
module tmin_bi_popcount #(
    parameter int W  = 36,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);

    // Sum of the set bits in bits_i.
    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CW'(bits_i[i]);
        end
    end

endmodule

// File: rtl/tmin_bi_lane.sv
// Module: tmin_bi_lane
// One encoder lane. It compares a valid input word with the word it drove last and
// drives the complement with polarity 1 when more than half of the bits would toggle.
// Assumes: active_i already combines enable and single-bus mode; outputs are
// registered, so results appear one clock after the valid cycle.
module tmin_bi_lane #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] word_o,
    output logic         pol_o
);

    localparam int            CW   = $clog2(W + 1);
    localparam logic [CW-1:0] HALF = CW'(W / 2);

    logic [W-1:0]  word_q;
    logic          pol_q;
    logic [CW-1:0] toggles;
    logic          invert;

    tmin_bi_popcount #(.W(W), .CW(CW)) u_count (
        .bits_i  (data_i ^ word_q),
        .count_o (toggles)
    );

    // Invert only while active and when strictly more than half of the bits toggle.
    always_comb begin
        invert = active_i && (toggles > HALF);
    end

    // Store the driven word on valid cycles; clear polarity while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            pol_q  <= 1'b0;
        end else begin
            if (valid_i) begin
                word_q <= invert ? ~data_i : data_i;
            end
            if (!active_i) begin
                pol_q <= 1'b0;
            end else if (valid_i) begin
                pol_q <= invert;
            end
        end
    end

    assign word_o = word_q;
    assign pol_o  = pol_q;

    // R2/R3: the driven word always decodes back to the input through the polarity line.
    p_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && active_i) |=> (word_q == ($past(data_i) ^ {W{pol_q}})));

    // R2/R4: after an active valid word, at most half of the lines changed.
    p_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && active_i) |=> ($countones(word_q ^ $past(word_q)) <= (W / 2)));

    // R5: a valid word while inactive passes through unchanged.
    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !active_i) |=> (word_q == $past(data_i)));

    // R5: polarity is low one clock after any inactive cycle.
    p_pol_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !pol_q);

    // R7: without valid, the stored word holds.
    p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(word_q));

    // R7: without valid while active, polarity holds.
    p_hold_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && active_i) |=> $stable(pol_q));

endmodule

// File: rtl/tmin_bus_inverter.sv
// Module: tmin_bus_inverter
// Top level. It has two independent encoder lanes, one for the odd bus and one for
// the even bus. Encoding is active only with enable high and single-bus mode low.
// Assumes: both buses share one clock; a lane that has no valid word holds its outputs.
module tmin_bus_inverter #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic         single_bus_i,
    input  logic [W-1:0] odd_data_i,
    input  logic         odd_valid_i,
    input  logic [W-1:0] even_data_i,
    input  logic         even_valid_i,
    output logic [W-1:0] odd_data_o,
    output logic         odd_pol_o,
    output logic [W-1:0] even_data_o,
    output logic         even_pol_o
);

    import tmin_bi_pkg::*;

    logic             active;
    logic [W-1:0]     lane_data [NUM_BUS];
    logic             lane_valid[NUM_BUS];
    logic [W-1:0]     lane_word [NUM_BUS];
    logic             lane_pol  [NUM_BUS];

    // Encoding is forced off in single-bus configuration.
    always_comb begin
        active = enable_i && !single_bus_i;
    end

    // Route the named bus ports onto the lane arrays.
    always_comb begin
        lane_data[BUS_ODD]   = odd_data_i;
        lane_valid[BUS_ODD]  = odd_valid_i;
        lane_data[BUS_EVEN]  = even_data_i;
        lane_valid[BUS_EVEN] = even_valid_i;
    end

    // R8: one self-contained lane per bus.
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_lane
        tmin_bi_lane #(.W(W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (active),
            .valid_i  (lane_valid[b]),
            .data_i   (lane_data[b]),
            .word_o   (lane_word[b]),
            .pol_o    (lane_pol[b])
        );
    end

    assign odd_data_o  = lane_word[BUS_ODD];
    assign odd_pol_o   = lane_pol[BUS_ODD];
    assign even_data_o = lane_word[BUS_EVEN];
    assign even_pol_o  = lane_pol[BUS_EVEN];

    // R6: in single-bus mode both polarity lines are low one clock later.
    p_single_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        single_bus_i |=> (!odd_pol_o && !even_pol_o));

    // R1: outputs are clear on the clock after a reset cycle.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (odd_data_o == '0 && even_data_o == '0 && !odd_pol_o && !even_pol_o));

endmodule

// File: tb/tmin_bus_inverter_tb.sv
// Bench for tmin_bus_inverter: toggle-count sweeps and a pseudo-random stream,
// checked against an arithmetic model of each lane.
module tmin_bus_inverter_tb;

    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         enable_i, single_bus_i;
    logic [W-1:0] odd_data_i, even_data_i;
    logic         odd_valid_i, even_valid_i;
    logic [W-1:0] odd_data_o, even_data_o;
    logic         odd_pol_o, even_pol_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [W-1:0] m_odd_w, m_even_w;
    logic         m_odd_p, m_even_p;

    always #2 clk = ~clk;   // 250 MHz

    tmin_bus_inverter #(.W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .single_bus_i (single_bus_i),
        .odd_data_i   (odd_data_i),
        .odd_valid_i  (odd_valid_i),
        .even_data_i  (even_data_i),
        .even_valid_i (even_valid_i),
        .odd_data_o   (odd_data_o),
        .odd_pol_o    (odd_pol_o),
        .even_data_o  (even_data_o),
        .even_pol_o   (even_pol_o)
    );

    // A word with exactly k set bits, rotated left by r.
    function automatic logic [W-1:0] kmask(int k, int r);
        logic [W-1:0] m;
        m = (k == 0) ? '0 : ({W{1'b1}} >> (W - k));
        if (r == 0) return m;
        return (m << r) | (m >> (W - r));
    endfunction

    task automatic check(string tag, logic [W-1:0] aw, logic ap, logic [W-1:0] ew, logic ep);
        n_checks++;
        if (aw !== ew || ap !== ep) begin
            n_fail++;
            $display("FAIL %s: got word=%h pol=%b expected word=%h pol=%b", tag, aw, ap, ew, ep);
        end
    endtask

    // Lane model: update the stored word and polarity after one clock.
    task automatic model_lane(inout logic [W-1:0] w, inout logic p,
                              input logic v, input logic [W-1:0] d, input logic act);
        if (v) begin
            if (act && $countones(d ^ w) > W / 2) begin
                w = ~d; p = 1'b1;
            end else begin
                w = d;  p = 1'b0;
            end
        end else if (!act) begin
            p = 1'b0;
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then check at the next falling edge.
    task automatic step(logic [W-1:0] od, logic ov, logic [W-1:0] ed, logic ev,
                        logic en, logic sb, string tag);
        logic act;
        odd_data_i = od; odd_valid_i = ov;
        even_data_i = ed; even_valid_i = ev;
        enable_i = en; single_bus_i = sb;
        act = en && !sb;
        @(negedge clk);
        model_lane(m_odd_w, m_odd_p, ov, od, act);
        model_lane(m_even_w, m_even_p, ev, ed, act);
        check({tag, " odd"},  odd_data_o,  odd_pol_o,  m_odd_w,  m_odd_p);
        check({tag, " even"}, even_data_o, even_pol_o, m_even_w, m_even_p);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] lfsr;
        rst_n = 1'b0; enable_i = 1'b1; single_bus_i = 1'b0;
        odd_data_i = '1; even_data_i = '1; odd_valid_i = 1'b1; even_valid_i = 1'b1;
        m_odd_w = '0; m_even_w = '0; m_odd_p = 1'b0; m_even_p = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset odd",  odd_data_o,  odd_pol_o,  '0, 1'b0);
        check("R1 reset even", even_data_o, even_pol_o, '0, 1'b0);
        rst_n = 1'b1;

        // R2/R3/R8: every toggle count, mirrored on the other bus.
        for (int k = 0; k <= W; k++) begin
            string tg;
            tg = (k > W / 2) ? "R2 sweep R8" : "R3 sweep R8";
            step(m_odd_w ^ kmask(k, k % W), 1'b1,
                 m_even_w ^ kmask(W - k, (3 * k) % W), 1'b1, 1'b1, 1'b0, tg);
        end

        // R3 boundary: exactly 18 passes, 19 inverts (R2).
        step(m_odd_w ^ kmask(18, 5), 1'b1, m_even_w ^ kmask(19, 7), 1'b1, 1'b1, 1'b0, "R3 R2 boundary");
        step(m_odd_w ^ kmask(19, 2), 1'b1, m_even_w ^ kmask(18, 0), 1'b1, 1'b1, 1'b0, "R2 R3 boundary");

        // R4: reset stored word to 0, then all ones twice; both must invert.
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        m_odd_w = '0; m_even_w = '0; m_odd_p = 1'b0; m_even_p = 1'b0;
        step('1, 1'b1, '0, 1'b1, 1'b1, 1'b0, "R4 first");
        step('1, 1'b1, '0, 1'b1, 1'b1, 1'b0, "R4 against driven word");
        check("R4 odd inverted again", odd_data_o, odd_pol_o, '0, 1'b1);

        // R7: idle cycles with changing data hold everything.
        for (int i = 0; i < 4; i++)
            step(kmask(i * 7 + 3, i), 1'b0, kmask(30 - i, i + 1), 1'b0, 1'b1, 1'b0, "R7 idle");

        // R5: set polarity, then disable without valid; polarity clears, data holds.
        step(~m_odd_w, 1'b1, ~m_even_w, 1'b1, 1'b1, 1'b0, "R2 set pol");
        step(kmask(9, 4), 1'b0, kmask(9, 4), 1'b0, 1'b0, 1'b0, "R5 pol clear");
        for (int i = 0; i < 4; i++)
            step(~m_odd_w ^ kmask(i, i), 1'b1, kmask(33, i), i[0], 1'b0, 1'b0, "R5 passthrough");

        // R6: single-bus forces pass-through even with enable high.
        step(~m_odd_w, 1'b1, ~m_even_w, 1'b1, 1'b1, 1'b0, "R2 set pol again");
        step('0, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R6 pol clear");
        for (int i = 0; i < 4; i++)
            step(~m_odd_w, 1'b1, ~m_even_w ^ kmask(i, 0), 1'b1, 1'b1, 1'b1, "R6 passthrough");

        // R2/R8: pseudo-random stream with mixed valid, enable and mode.
        lfsr = 36'h9_A5C3_1E77;
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] a, b;
            lfsr = {lfsr[W-2:0], lfsr[W-1] ^ lfsr[24]};
            a = lfsr;
            b = {lfsr[17:0], lfsr[W-1:18]} ^ kmask(i % 37, i % W);
            step(a, lfsr[3] | lfsr[9], b, lfsr[5] | lfsr[11], lfsr[7] | lfsr[2],
                 (lfsr[13] & lfsr[21] & lfsr[1]), "R2 random R8");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule